// File: doc/BRIEF.md
# Per-Core Timer and Watchdog Window Router

This block sits in front of a cluster's private timers. Each core in a cluster of one to four cores owns one timer and one watchdog. Both have the same small register file. The block takes one 32-bit register access per cycle and decodes which 32-byte window it falls in. It steers the access to one of the `2*NUM_CORES` instances and returns the read data one cycle later. Two windows are shared by all cores. Window 0 reaches the timer of the core that issues the access, and window 1 reaches that core's watchdog. The core is identified by the `req_core` ID that travels with the request, not by the address. The remaining windows reach every instance directly. The interrupt of each instance appears on one bit of a combined vector, in the same order as the instances.

`req_addr` is the byte offset from the block's base, because the base has already been removed upstream. The window index is `req_addr[WIN_W+4:5]` and the word offset inside the window is `req_addr[4:2]`. An access that cannot be routed is flagged as an error. An error access never reaches an instance, and its response carries `rsp_err`. `NUM_CORES` must lie between 1 and 4.

The response path is a three-state machine:
- **ST_IDLE** means no response is driven.
- **ST_ACK** drives a normal response.
- **ST_FAULT** drives an error response.

Every state follows the same transition rules:
- A cycle with `req_valid` low goes to ST_IDLE.
- A routable request goes to ST_ACK.
- A request that decodes as an error goes to ST_FAULT.

Back-to-back requests therefore move directly between ST_ACK and ST_FAULT.

Top module: `core_timer_router`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next cycle. A cycle without a request produces no response.
- R2: The window index is `req_addr[WIN_W+4:5]`. Window 2+2k reaches the timer of core k and window 3+2k reaches the watchdog of core k. The instance index is 2k for a timer and 2k+1 for a watchdog.
- R3: Window 0 reaches the timer of core `req_core` and window 1 reaches the watchdog of core `req_core`.
- R4: An access to window 0 or 1 with `req_core` >= NUM_CORES is an error.
- R5: An access to a window index >= 2+2*NUM_CORES is an error.
- R6: An access with `req_size` other than 2'b10 (word), or with `req_addr[1:0]` not 2'b00, is an error.
- R7: An error response has `rsp_err` high together with `rsp_valid` for that single cycle, with `rsp_rdata` zero. The write of an error access changes no instance. `rsp_err` is never high without `rsp_valid`.
- R8: Bit 2k of `irq` is the interrupt of timer k and bit 2k+1 is the interrupt of watchdog k. An instance's interrupt is bit 0 of its word at offset 0xC (`req_addr[4:2]` = 3), and it updates on the cycle after the write.
- R9: Each instance holds four 32-bit words at offsets 0x0 to 0xC that read back what was written and are zero after reset. Offsets 0x10 to 0x1C read zero and ignore writes.
- R10: A write response carries `rsp_rdata` zero. A read response carries the addressed word as it was before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | WIN_W+5 | Byte offset from the block base |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_core | input | 2 | ID of the requesting core |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Registered read data |
| irq | output | 2*NUM_CORES | Instance interrupts, timer/watchdog interleaved per core |

## Verification
The bench runs with three cores, so a core ID of 3 is legal in width but out of range. This catches a design that checks the ID against the field width instead of the configured count: that design would let the access reach a nonexistent instance or wrap to another core's instance. Every instance is loaded with a distinct value, and the shared windows are then read from each core. A router that swapped timer and watchdog, or ignored the core ID, would return another instance's value.

Error writes of each kind are followed by read-back of every instance. A router that merely flagged the error while still writing would be exposed. Writes to the upper window offsets and to the interrupt words check that interrupts land on the interleaved bit positions and that the ignored offsets stay zero.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    localparam int CORE_W    = 2;
    localparam int INST_W    = 3;
    localparam int DATA_W    = 32;
    localparam int OFF_W     = 3;
    localparam int STUB_WORDS = 4;
    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACK   = 2'd1,
        ST_FAULT = 2'd2
    } rsp_state_e;

    typedef struct packed {
        logic              err;
        logic [INST_W-1:0] inst;
    } route_t;
endpackage

// File: rtl/ctr_window_decode.sv
module ctr_window_decode
    import ctr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int WIN_W     = 4
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [1:0]        low,
    input  logic [1:0]        size,
    input  logic [CORE_W-1:0] core,
    output route_t            route
);
    localparam int NUM_WIN = 2 + 2 * NUM_CORES;

    always_comb begin
        route.err  = 1'b0;
        route.inst = '0;
        if (size != SIZE_WORD || low != 2'b00) begin
            route.err = 1'b1;                                 // R6
        end else if (win == WIN_W'(0)) begin
            route.inst = INST_W'({core, 1'b0});               // R3 timer of requester
            route.err  = (32'(core) >= NUM_CORES);            // R4
        end else if (win == WIN_W'(1)) begin
            route.inst = INST_W'({core, 1'b1});               // R3 watchdog of requester
            route.err  = (32'(core) >= NUM_CORES);            // R4
        end else if (32'(win) < NUM_WIN) begin
            route.inst = INST_W'(32'(win) - 2);               // R2 direct windows
        end else begin
            route.err = 1'b1;                                 // R5
        end
    end
endmodule

// File: rtl/ctr_regfile_stub.sv
module ctr_regfile_stub
    import ctr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] regs [STUB_WORDS];
    logic              in_range;

    assign in_range = (32'(offset) < STUB_WORDS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STUB_WORDS; i++) regs[i] <= '0;
        end else if (wr_en && in_range) begin
            regs[offset[1:0]] <= wdata;
        end
    end

    assign rdata = in_range ? regs[offset[1:0]] : '0;
    assign irq   = regs[STUB_WORDS-1][0];

    p_high_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_range) |=> ($stable(regs[0]) && $stable(regs[1]) &&
                                  $stable(regs[2]) && $stable(regs[3])));

    p_irq_only_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(irq));
endmodule

// File: rtl/core_timer_router.sv
module core_timer_router
    import ctr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int WIN_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [WIN_W+4:0]       req_addr,
    input  logic [1:0]             req_size,
    input  logic [CORE_W-1:0]      req_core,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [2*NUM_CORES-1:0] irq
);
    localparam int NUM_INST = 2 * NUM_CORES;

    route_t            route;
    rsp_state_e        state;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] inst_rdata [NUM_INST];
    logic [NUM_INST-1:0] wr_vec;
    logic [DATA_W-1:0] sel_rdata;
    logic              wr_fire;

    ctr_window_decode #(.NUM_CORES(NUM_CORES), .WIN_W(WIN_W)) u_decode (
        .win  (req_addr[WIN_W+4:5]),
        .low  (req_addr[1:0]),
        .size (req_size),
        .core (req_core),
        .route(route)
    );

    assign wr_fire = req_valid && req_write && !route.err;

    for (genvar g = 0; g < NUM_INST; g++) begin : g_inst
        assign wr_vec[g] = wr_fire && (route.inst == INST_W'(g));
        ctr_regfile_stub u_stub (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_vec[g]),
            .offset(req_addr[4:2]),
            .wdata (req_wdata),
            .rdata (inst_rdata[g]),
            .irq   (irq[g])
        );
    end

    always_comb begin
        sel_rdata = '0;
        for (int i = 0; i < NUM_INST; i++)
            if (route.inst == INST_W'(i)) sel_rdata = inst_rdata[i];
    end

    // State register and captured read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rdata_q <= '0;
        end else if (req_valid) begin
            state   <= route.err ? ST_FAULT : ST_ACK;
            rdata_q <= (route.err || req_write) ? '0 : sel_rdata;
        end else begin
            state   <= ST_IDLE;
            rdata_q <= '0;
        end
    end

    // Outputs from state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state)
            ST_IDLE:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
            ST_ACK:   begin rsp_valid = 1'b1; rsp_err = 1'b0; end
            ST_FAULT: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default:  begin rsp_valid = 1'b0; rsp_err = 1'b0; end
        endcase
    end
    assign rsp_rdata = rdata_q;

    p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_err_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);
    p_err_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));
    p_err_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && route.err) |-> (wr_vec == '0));
    p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));
    p_write_zero_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));
    p_alias_core_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !route.err && (req_addr[WIN_W+4:6] == '0))
            |-> (32'(req_core) < NUM_CORES));
endmodule

// File: tb/core_timer_router_tb_top.sv
`timescale 1ns/1ps
module core_timer_router_tb_top;
    localparam int NC      = 3;
    localparam int WW      = 4;
    localparam int NINST   = 2 * NC;
    localparam int NWIN    = 2 + 2 * NC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [WW+4:0]     req_addr = '0;
    logic [1:0]        req_size = 2'b10;
    logic [1:0]        req_core = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [31:0]       rsp_rdata;
    logic [NINST-1:0]  irq;

    always #2 clk = ~clk;   // 250 MHz

    core_timer_router #(.NUM_CORES(NC), .WIN_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_core(req_core),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .irq(irq)
    );

    typedef struct {
        logic        err;
        logic [31:0] data;
        int          stamp;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] model [NINST][4];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: called at a negedge, drives one request and pushes the expected response
    task automatic access(bit wr, int win, int off, logic [31:0] wd, int core,
                          logic [1:0] size, logic [1:0] low);
        exp_t e;
        bit err;
        int inst;
        string tag;
        err = 1'b0; inst = 0;
        tag = (win < 2) ? "R3" : "R2";
        if (size != 2'b10 || low != 2'b00) begin err = 1'b1; tag = "R6"; end
        else if (win >= NWIN) begin err = 1'b1; tag = "R5"; end
        else if (win < 2 && core >= NC) begin err = 1'b1; tag = "R4"; end
        else inst = (win < 2) ? 2 * core + win : win - 2;
        if (off >= 4) tag = {tag, "/R9"};
        e.err   = err;
        e.data  = (err || wr || off >= 4) ? 32'h0 : model[inst][off];
        e.stamp = cyc;
        e.tag   = wr ? {tag, "/R10"} : tag;
        if (err) e.tag = {e.tag, "/R7"};
        if (wr && !err && off < 4) model[inst][off] = wd;
        sb_q.push_back(e);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {4'(win), 3'(off), low};
        req_size  = size;
        req_core  = 2'(core);
        req_wdata = wd;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        req_write = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NINST-1:0] exp_irq();
        logic [NINST-1:0] v;
        for (int i = 0; i < NINST; i++) v[i] = model[i][3][0];
        return v;
    endfunction

    // Monitor: pops and compares at the negedge after the accepting posedge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_err && !rsp_valid)
                check(1'b0, "R7 err without valid", 32'(rsp_err), 32'h0);
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R1 unexpected response", 32'(rsp_valid), 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(cyc == e.stamp + 1, {"R1 latency ", e.tag}, 32'(cyc), 32'(e.stamp + 1));
                    check(rsp_err == e.err, {"err flag ", e.tag}, 32'(rsp_err), 32'(e.err));
                    check(rsp_rdata == e.data, {"rdata ", e.tag}, rsp_rdata, e.data);
                end
            end else if (sb_q.size() != 0 && sb_q[0].stamp + 1 < cyc) begin
                check(1'b0, "R1 missing response", 32'h0, 32'h1);
                void'(sb_q.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < NINST; i++)
            for (int j = 0; j < 4; j++) model[i][j] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 reset valid", 32'(rsp_valid), 32'h0);
        check(irq == '0, "R8 reset irq", 32'(irq), 32'h0);
        // R9 reset contents read zero through every direct window
        for (int w = 2; w < NWIN; w++) access(0, w, 0, 0, 0, 2'b10, 2'b00);
        idle(1);
        // R2 load distinct values through direct windows, back to back
        for (int w = 2; w < NWIN; w++) access(1, w, 0, 32'hA000_0000 + 32'(w), 0, 2'b10, 2'b00);
        for (int w = 2; w < NWIN; w++) access(1, w, 1, 32'h5100_0000 + 32'(w << 4), 1, 2'b10, 2'b00);
        for (int w = 2; w < NWIN; w++) access(0, w, 0, 0, 2, 2'b10, 2'b00);
        for (int w = 2; w < NWIN; w++) access(0, w, 1, 0, 0, 2'b10, 2'b00);
        idle(2);
        // R3 shared windows steered by requesting core
        for (int c = 0; c < NC; c++) begin
            access(0, 0, 0, 0, c, 2'b10, 2'b00);
            access(0, 1, 0, 0, c, 2'b10, 2'b00);
        end
        access(1, 1, 2, 32'hC0DE_0001, 1, 2'b10, 2'b00);  // R3 watchdog of core 1
        access(0, 5, 2, 0, 0, 2'b10, 2'b00);
        access(1, 0, 2, 32'hC0DE_0002, 2, 2'b10, 2'b00);  // R3 timer of core 2
        access(0, 6, 2, 0, 0, 2'b10, 2'b00);
        idle(1);
        // R4 out-of-range core on shared windows
        access(0, 0, 0, 0, 3, 2'b10, 2'b00);
        access(1, 1, 0, 32'hDEAD_0004, 3, 2'b10, 2'b00);
        access(1, 0, 1, 32'hDEAD_0014, 3, 2'b10, 2'b00);
        // R5 window past the last core
        access(0, NWIN, 0, 0, 0, 2'b10, 2'b00);
        access(1, 15, 0, 32'hDEAD_0005, 0, 2'b10, 2'b00);
        // R6 narrow and misaligned accesses
        access(1, 2, 0, 32'hDEAD_0006, 0, 2'b00, 2'b00);
        access(1, 3, 0, 32'hDEAD_0016, 0, 2'b01, 2'b00);
        access(1, 4, 0, 32'hDEAD_0026, 0, 2'b10, 2'b10);
        access(0, 2, 0, 0, 0, 2'b10, 2'b01);
        idle(1);
        // R7 no instance changed by error writes
        for (int w = 2; w < NWIN; w++) begin
            access(0, w, 0, 0, 0, 2'b10, 2'b00);
            access(0, w, 1, 0, 0, 2'b10, 2'b00);
        end
        idle(1);
        // R9 upper offsets ignore writes and read zero
        access(1, 4, 5, 32'hFFFF_FFFF, 0, 2'b10, 2'b00);
        access(0, 4, 5, 0, 0, 2'b10, 2'b00);
        access(0, 4, 0, 0, 0, 2'b10, 2'b00);
        idle(1);
        // R8 interrupt order
        access(1, 5, 3, 32'h1, 0, 2'b10, 2'b00);   // watchdog core 1 -> bit 3
        idle(1);
        check(irq == exp_irq(), "R8 irq watchdog1", 32'(irq), 32'(exp_irq()));
        access(1, 2, 3, 32'h1, 0, 2'b10, 2'b00);   // timer core 0 -> bit 0
        access(1, 0, 3, 32'h3, 2, 2'b10, 2'b00);   // timer core 2 via alias -> bit 4
        idle(1);
        check(irq == exp_irq(), "R8 irq timer0/timer2", 32'(irq), 32'(exp_irq()));
        access(1, 5, 3, 32'h0, 0, 2'b10, 2'b00);
        access(1, 1, 3, 32'h1, 3, 2'b10, 2'b00);   // error: must not set any bit
        idle(1);
        check(irq == exp_irq(), "R8/R7 irq after clear", 32'(irq), 32'(exp_irq()));
        idle(3);
        check(sb_q.size() == 0, "R1 all responses seen", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule